// File: doc/BRIEF.md
# Frame Buffer Row Fill Engine

This block fills a run of 16-bit words in a double-buffered frame memory without help from the processor. Software sets a word count and a start address in two registers. It then writes the fill word to a third register, and that write starts the engine. From the next clock on, the engine issues one write per cycle into the back buffer, which is the buffer not shown on screen. It raises a busy flag for as long as the run lasts.

Each step advances only the low eight bits of the address, so a run never leaves the 256-word row in which it began. When the run ends, the start register holds the address that follows the last word written. A second fill word therefore continues the same row from that point.

Top module: `fbf_fill_engine`

## Requirements
- R1: While reset is held, and at the first clock after its release, `busy` and `mem_we` are 0 and `fill_len`, `fill_start` and `fill_data` read 0.
- R2: `reg_sel` = 0 selects the count register. A 16-bit write (`reg_wide` = 1) or an 8-bit write to the odd byte (`reg_wide` = 0, `reg_odd` = 1) loads `reg_wdata[7:0]` into `fill_len`. An 8-bit write to the even byte leaves the register unchanged.
- R3: `reg_sel` = 1 selects the start register. Only a 16-bit write loads all of `reg_wdata` into `fill_start`. An 8-bit write to this offset has no effect.
- R4: A 16-bit write with `reg_sel` = 2 stores `reg_wdata` in `fill_data` and starts a run. The first memory write is presented in the cycle after that write, with `mem_addr` equal to the start address and `mem_wdata` equal to the fill word. An 8-bit write to this offset neither stores the word nor starts a run.
- R5: From one memory write to the next, `mem_addr[7:0]` increases by 1 modulo 256 and `mem_addr[15:8]` stays unchanged.
- R6: When a run ends, `fill_start` holds the low-byte-incremented address that follows the last word written.
- R7: `mem_bank` equals the inverse of `frame_sel` as sampled at the starting write, and it stays fixed for the whole run even if `frame_sel` changes.
- R8: A run makes exactly `fill_len` + 1 memory writes, one per clock with no gaps. `busy` is high in exactly those cycles.
- R9: All register writes that arrive while `busy` is high are ignored, including a new start.
- R10: `reg_sel` = 3 is unused. Writes to it change no register and start no run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_wide | input | 1 | 1 = 16-bit write, 0 = 8-bit write |
| reg_odd | input | 1 | Byte lane of an 8-bit write, 1 = odd (low-order) byte |
| reg_sel | input | 2 | Register select: 0 count, 1 start, 2 fill word, 3 unused |
| reg_wdata | input | 16 | Write data; 8-bit writes use bits 7:0 |
| frame_sel | input | 1 | Buffer currently shown on screen |
| busy | output | 1 | High while a run is in progress |
| fill_len | output | 8 | Count register (words written minus one) |
| fill_start | output | 16 | Start / next address register |
| fill_data | output | 16 | Last stored fill word |
| mem_we | output | 1 | Memory write enable |
| mem_bank | output | 1 | Target buffer of the write |
| mem_addr | output | 16 | Word address of the write |
| mem_wdata | output | 16 | Word to write |

## Verification
A table of runs covers several cases. A single-word run checks the +1 count at its lowest value. A run that starts near the end of a row shows that the carry stays out of the high byte. A full 256-word run returns to its own start address, and a run whose low byte crosses 0xFF shows that the end address is kept modulo the row. Each run alternates `frame_sel`, so a bank error appears at once. Directed tests separate the byte-lane decodes, the ignored unused offset and the ignored writes during a run. They also cover a `frame_sel` change in the middle of a run, which must not move the target bank.

// File: rtl/fbf_pkg.sv
package fbf_pkg;
  typedef enum logic [1:0] {
    FBF_SEL_LEN   = 2'd0,
    FBF_SEL_START = 2'd1,
    FBF_SEL_DATA  = 2'd2,
    FBF_SEL_NONE  = 2'd3
  } fbf_sel_e;
endpackage

// File: rtl/fbf_rst_sync.sv
module fbf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_n;

  always_comb begin
    sync_n = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_n;
  end

  assign rst_q = sync_q[STAGES-1];
endmodule

// File: rtl/fbf_row_inc.sv
module fbf_row_inc #(
  parameter int ADDR_W = 16,
  parameter int ROW_W  = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ROW_W-1:0] low_inc;

  assign low_inc = addr_i[ROW_W-1:0] + {{(ROW_W-1){1'b0}}, 1'b1};

  generate
    if (ROW_W >= ADDR_W) begin : g_flat
      assign addr_o = low_inc[ADDR_W-1:0];
    end else begin : g_row
      assign addr_o = {addr_i[ADDR_W-1:ROW_W], low_inc};
    end
  endgenerate
endmodule

// File: rtl/fbf_regs.sv
module fbf_regs
  import fbf_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_wide,
  input  logic              wr_odd,
  input  fbf_sel_e          wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              step,
  input  logic [ADDR_W-1:0] step_addr,
  output logic [LEN_W-1:0]  len_q,
  output logic [ADDR_W-1:0] start_q,
  output logic [DATA_W-1:0] data_q,
  output logic              go
);
  logic [LEN_W-1:0]  len_n;
  logic [ADDR_W-1:0] start_n;
  logic [DATA_W-1:0] data_n;
  logic              len_en, start_en;

  always_comb begin
    len_en   = wr_en && (wr_sel == FBF_SEL_LEN) && (wr_wide || wr_odd);
    start_en = wr_en && wr_wide && (wr_sel == FBF_SEL_START);
    go       = wr_en && wr_wide && (wr_sel == FBF_SEL_DATA);

    len_n   = len_q;
    start_n = start_q;
    data_n  = data_q;
    if (len_en)   len_n   = wr_data[LEN_W-1:0];
    if (start_en) start_n = wr_data[ADDR_W-1:0];
    if (step)     start_n = step_addr;
    if (go)       data_n  = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q   <= '0;
      start_q <= '0;
      data_q  <= '0;
    end else begin
      len_q   <= len_n;
      start_q <= start_n;
      data_q  <= data_n;
    end
  end
endmodule

// File: rtl/fbf_seq.sv
module fbf_seq #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [LEN_W-1:0] len,
  input  logic             frame_sel,
  output logic             busy_q,
  output logic             bank_q
);
  logic [LEN_W-1:0] cnt_q, cnt_n;
  logic             busy_n, bank_n;

  always_comb begin
    busy_n = busy_q;
    cnt_n  = cnt_q;
    bank_n = bank_q;
    if (go) begin
      busy_n = 1'b1;
      cnt_n  = len;
      bank_n = ~frame_sel;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_n = 1'b0;
      else             cnt_n  = cnt_q - {{(LEN_W-1){1'b0}}, 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      bank_q <= 1'b0;
    end else begin
      busy_q <= busy_n;
      cnt_q  <= cnt_n;
      bank_q <= bank_n;
    end
  end
endmodule

// File: rtl/fbf_fill_engine.sv
module fbf_fill_engine
  import fbf_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int LEN_W  = 8,
  parameter int ROW_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic              reg_wide,
  input  logic              reg_odd,
  input  logic [1:0]        reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              frame_sel,
  output logic              busy,
  output logic [LEN_W-1:0]  fill_len,
  output logic [ADDR_W-1:0] fill_start,
  output logic [DATA_W-1:0] fill_data,
  output logic              mem_we,
  output logic              mem_bank,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);
  logic              rst_q;
  logic              wr_ok, go, busy_q, bank_q;
  logic [ADDR_W-1:0] next_addr;

  fbf_rst_sync #(.STAGES(2)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_q (rst_q)
  );

  assign wr_ok = reg_we && !busy_q;

  fbf_row_inc #(.ADDR_W(ADDR_W), .ROW_W(ROW_W)) u_inc (
    .addr_i (fill_start),
    .addr_o (next_addr)
  );

  fbf_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_q),
    .wr_en     (wr_ok),
    .wr_wide   (reg_wide),
    .wr_odd    (reg_odd),
    .wr_sel    (fbf_sel_e'(reg_sel)),
    .wr_data   (reg_wdata),
    .step      (busy_q),
    .step_addr (next_addr),
    .len_q     (fill_len),
    .start_q   (fill_start),
    .data_q    (fill_data),
    .go        (go)
  );

  fbf_seq #(.LEN_W(LEN_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_q),
    .go        (go),
    .len       (fill_len),
    .frame_sel (frame_sel),
    .busy_q    (busy_q),
    .bank_q    (bank_q)
  );

  assign busy      = busy_q;
  assign mem_we    = busy_q;
  assign mem_bank  = bank_q;
  assign mem_addr  = fill_start;
  assign mem_wdata = fill_data;
endmodule

// File: rtl/fbf_fill_engine_chk.sv
module fbf_fill_engine_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int LEN_W  = 8,
  parameter int ROW_W  = 8
) (
  input logic              clk,
  input logic              rst_q,
  input logic              reg_we,
  input logic              reg_wide,
  input logic [1:0]        reg_sel,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              frame_sel,
  input logic              busy,
  input logic [LEN_W-1:0]  fill_len,
  input logic [ADDR_W-1:0] fill_start,
  input logic [DATA_W-1:0] fill_data,
  input logic              mem_we,
  input logic              mem_bank,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata
);
  logic [LEN_W:0] beats_q;

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)      beats_q <= '0;
    else if (mem_we) beats_q <= beats_q + 1'b1;
    else             beats_q <= '0;
  end

  always_comb begin
    if (rst_q === 1'b0) begin
      a_reset_idle_r1: assert (mem_we == 1'b0 && busy == 1'b0);
    end
  end

  p_launch_r4: assert property (@(posedge clk) disable iff (!rst_q)
    (reg_we && reg_wide && reg_sel == 2'd2 && !busy) |=>
      (mem_we && mem_addr == $past(fill_start) && mem_wdata == $past(reg_wdata)));

  p_row_step_r5: assert property (@(posedge clk) disable iff (!rst_q)
    (mem_we && $past(mem_we)) |->
      (mem_addr[ADDR_W-1:ROW_W] == $past(mem_addr[ADDR_W-1:ROW_W]) &&
       mem_addr[ROW_W-1:0] == $past(mem_addr[ROW_W-1:0]) + 1'b1));

  p_end_addr_r6: assert property (@(posedge clk) disable iff (!rst_q)
    $fell(busy) |->
      (fill_start[ADDR_W-1:ROW_W] == $past(mem_addr[ADDR_W-1:ROW_W]) &&
       fill_start[ROW_W-1:0] == $past(mem_addr[ROW_W-1:0]) + 1'b1));

  p_bank_pick_r7: assert property (@(posedge clk) disable iff (!rst_q)
    (reg_we && reg_wide && reg_sel == 2'd2 && !busy) |=> (mem_bank == !$past(frame_sel)));

  p_bank_hold_r7: assert property (@(posedge clk) disable iff (!rst_q)
    (mem_we && $past(mem_we)) |-> $stable(mem_bank));

  p_beats_r8: assert property (@(posedge clk) disable iff (!rst_q)
    $fell(busy) |-> (beats_q == {1'b0, fill_len} + 1'b1));

  p_ignore_busy_r9: assert property (@(posedge clk) disable iff (!rst_q)
    busy |=> ($stable(fill_len) && $stable(fill_data)));
endmodule

bind fbf_fill_engine fbf_fill_engine_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .ROW_W(ROW_W)
) u_chk (
  .clk        (clk),
  .rst_q      (rst_q),
  .reg_we     (reg_we),
  .reg_wide   (reg_wide),
  .reg_sel    (reg_sel),
  .reg_wdata  (reg_wdata),
  .frame_sel  (frame_sel),
  .busy       (busy),
  .fill_len   (fill_len),
  .fill_start (fill_start),
  .fill_data  (fill_data),
  .mem_we     (mem_we),
  .mem_bank   (mem_bank),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata)
);

// File: tb/sim_fbf_fill_engine.sv
module sim_fbf_fill_engine;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we, reg_wide, reg_odd, frame_sel;
  logic [1:0]  reg_sel;
  logic [15:0] reg_wdata;
  logic        busy, mem_we, mem_bank;
  logic [7:0]  fill_len;
  logic [15:0] fill_start, fill_data, mem_addr, mem_wdata;

  int n_chk = 0;
  int n_fail = 0;
  int beat_cnt = 0;
  int bank_err = 0;
  logic exp_bank = 1'b0;

  always #10 clk = ~clk;

  fbf_fill_engine u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wide(reg_wide),
    .reg_odd(reg_odd), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .frame_sel(frame_sel), .busy(busy), .fill_len(fill_len),
    .fill_start(fill_start), .fill_data(fill_data), .mem_we(mem_we),
    .mem_bank(mem_bank), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  always @(negedge clk) begin
    if (mem_we) begin
      beat_cnt = beat_cnt + 1;
      if (mem_bank !== exp_bank) bank_err = bank_err + 1;
    end
  end

  // {frame_sel, len, start, data}
  localparam logic [40:0] VEC [5] = '{
    {1'b0, 8'd0,   16'h0010, 16'hA5A5},
    {1'b1, 8'd3,   16'h12FE, 16'h1234},
    {1'b0, 8'd7,   16'h8000, 16'hFFFF},
    {1'b1, 8'd255, 16'h3400, 16'h0F0F},
    {1'b0, 8'd16,  16'hABF8, 16'h5A5A}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic wide, input logic odd, input logic [15:0] d);
    reg_we = 1'b1; reg_sel = sel; reg_wide = wide; reg_odd = odd; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  function automatic logic [15:0] row_add(input logic [15:0] a, input int k);
    logic [7:0] lo;
    lo = a[7:0] + k[7:0];
    return {a[15:8], lo};
  endfunction

  initial begin
    #(200000 * 20);
    n_fail = n_fail + 1;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] s_end;
    int beats0;
    rst_n = 1'b0; reg_we = 1'b0; reg_wide = 1'b0; reg_odd = 1'b0;
    reg_sel = 2'd0; reg_wdata = '0; frame_sel = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy == 0 && mem_we == 0, "R1 busy/we in reset", {busy, mem_we}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && mem_we == 0 && fill_len == 0 && fill_start == 0 && fill_data == 0,
        "R1 state after release", {fill_len, fill_start}, 0);
    repeat (3) @(negedge clk);

    // table of runs
    for (int v = 0; v < 5; v++) begin
      logic       fs;
      logic [7:0] ln;
      logic [15:0] st, dt;
      {fs, ln, st, dt} = VEC[v];
      wr(2'd0, 1'b0, 1'b1, {8'h00, ln});
      wr(2'd1, 1'b1, 1'b0, st);
      frame_sel = fs;
      exp_bank = ~fs;
      wr(2'd2, 1'b1, 1'b0, dt);
      chk(fill_data == dt, "R4 fill word stored", fill_data, dt);
      for (int i = 0; i <= int'(ln); i++) begin
        chk(busy && mem_we, "R8 busy during run", {busy, mem_we}, 2'b11);
        chk(mem_addr == row_add(st, i), "R5 row address", mem_addr, row_add(st, i));
        chk(mem_wdata == dt, "R4 write data", mem_wdata, dt);
        chk(mem_bank == ~fs, "R7 back buffer", mem_bank, ~fs);
        @(negedge clk);
      end
      chk(!busy && !mem_we, "R8 run length", {busy, mem_we}, 0);
      s_end = row_add(st, int'(ln) + 1);
      chk(fill_start == s_end, "R6 end address", fill_start, s_end);
    end

    // R2: even byte ignored, 16-bit loads low byte
    wr(2'd0, 1'b0, 1'b1, 16'h0005);
    wr(2'd0, 1'b0, 1'b0, 16'h0077);
    chk(fill_len == 8'h05, "R2 even byte ignored", fill_len, 8'h05);
    wr(2'd0, 1'b1, 1'b0, 16'h9C06);
    chk(fill_len == 8'h06, "R2 wide write loads low byte", fill_len, 8'h06);

    // R3: 8-bit start write ignored
    wr(2'd1, 1'b1, 1'b0, 16'h4410);
    wr(2'd1, 1'b0, 1'b1, 16'h00EE);
    wr(2'd1, 1'b0, 1'b0, 16'h00DD);
    chk(fill_start == 16'h4410, "R3 byte write to start ignored", fill_start, 16'h4410);

    // R4: byte write to data offset starts nothing
    wr(2'd2, 1'b0, 1'b1, 16'h00C3);
    chk(!busy && !mem_we && fill_data == 16'h5A5A, "R4 byte write to data no run",
        {busy, fill_data}, 16'h5A5A);

    // R10: unused offset
    wr(2'd3, 1'b1, 1'b0, 16'hBEEF);
    chk(!busy && fill_len == 8'h06 && fill_start == 16'h4410 && fill_data == 16'h5A5A,
        "R10 unused offset", {fill_len, fill_start}, {8'h06, 16'h4410});

    // R9 and R7: writes and frame change during a run (len 6, start 4410)
    frame_sel = 1'b1;
    exp_bank = 1'b0;
    beats0 = beat_cnt;
    bank_err = 0;
    wr(2'd2, 1'b1, 1'b0, 16'h7E7E);
    frame_sel = 1'b0;
    wr(2'd0, 1'b0, 1'b1, 16'h0033);
    wr(2'd1, 1'b1, 1'b0, 16'h0000);
    wr(2'd2, 1'b1, 1'b0, 16'h1111);
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(fill_len == 8'h06, "R9 count held", fill_len, 8'h06);
    chk(fill_data == 16'h7E7E, "R9 fill word held", fill_data, 16'h7E7E);
    chk(fill_start == 16'h4417, "R9 start not overwritten", fill_start, 16'h4417);
    chk(beat_cnt - beats0 == 7, "R9 no second run", beat_cnt - beats0, 7);
    chk(bank_err == 0, "R7 bank fixed during run", bank_err, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule